// File: doc/BRIEF.md
# System Control Register Bank

This block is a 4 KiB window of 32-bit control and status words on a simple single-cycle bus. One valid strobe, qualified by a write flag, moves one word per cycle. Writes go to the word chosen by the byte address with its two low bits dropped. A read strobe returns that word one cycle later.

Four words near the start of the window hold non-zero identification values after reset. Every other word reads as zero until software writes it. Three of the identification words always read with two status bits set, whatever was stored there.

One word acts as a command port. A write to that word is stored like any other write. Its data value also decides whether the block raises a one-cycle request to reset the system, a one-cycle request to power it down, or nothing. The block does not carry out either request; it only signals it.

Top module: `sysctl_bank`

## Requirements
- R1: A write (bus_valid=1, bus_write=1) stores bus_wdata in word bus_addr[11:2]. A later read of that word puts the stored value on rd_data in the cycle after the read strobe. Address bits 1:0 are ignored, and rd_data holds its value between reads.
- R2: While rst is high and right after it falls, rd_data, reset_req and shutdown_req are 0. Any word that is not preset and has not been written since reset reads as 0x00000000.
- R3: After reset, word 0x40 (byte 0x100) holds 0x05F20121, word 0x41 (byte 0x104) holds 0x00000002, word 0x42 (byte 0x108) holds 0x05F30121 and word 0x43 (byte 0x10C) holds 0x05F40121.
- R4: Reads at byte offsets 0x100, 0x108 and 0x10C return the stored word ORed with 0x30000000, so bits 29 and 28 read as one. The stored word itself is not changed, and no other offset is affected.
- R5: A write of 1 or 2 to byte offset 0xF00 drives reset_req high for exactly the one cycle after the write.
- R6: A write of 3 to byte offset 0xF00 drives shutdown_req high for exactly the one cycle after the write.
- R7: A write of any other value to byte offset 0xF00 raises no request. Every write to 0xF00 is stored and reads back unchanged.
- R8: A write of 1, 2 or 3 to any offset other than 0xF00 raises no request.
- R9: reset_req and shutdown_req are never high in the same cycle.
- R10: Bus strobes are ignored while rst is high: nothing is stored and no request is raised. A request pulse that has already started still lasts its full cycle if rst rises during it.
- R11: Asserting rst returns every word to its R3 or zero value, including words written before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the bank |
| bus_valid | input | 1 | Access strobe, one access per cycle |
| bus_write | input | 1 | 1 = write, 0 = read, when bus_valid is high |
| bus_addr | input | 12 | Byte address in the window; bits 1:0 ignored |
| bus_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid the cycle after a read strobe |
| reset_req | output | 1 | One-cycle system reset request |
| shutdown_req | output | 1 | One-cycle system power-down request |

## Verification
Two functions can act in the same cycle. A write to the command word is both a store and a request decode. Also, a request pulse that is in flight can coincide with the bank's own reset. The bench writes command values 0 to 4 to 0xF00, checks the request lines in the cycle after each write, and reads the word back to show that the store still happened. It also raises rst exactly in the pulse cycle, and checks that the pulse is still present there and gone one cycle later.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  // Word index of the command port (byte 0xF00).
  localparam int unsigned CMD_WORD   = 'h3C0;
  // Bits forced to one on reads of some status words.
  localparam logic [31:0] FORCE_MASK = 32'h3000_0000;

  typedef enum logic [1:0] {
    REQ_NONE     = 2'd0,
    REQ_RESET    = 2'd1,
    REQ_SHUTDOWN = 2'd2
  } req_kind_t;

  function automatic req_kind_t decode_cmd(input logic [31:0] value);
    if (value == 32'd1 || value == 32'd2) return REQ_RESET;
    if (value == 32'd3)                   return REQ_SHUTDOWN;
    return REQ_NONE;
  endfunction

  // Value a word holds right after reset.
  function automatic logic [31:0] preset_value(input int unsigned idx);
    case (idx)
      'h40:    return 32'h05F2_0121;
      'h41:    return 32'h0000_0002;
      'h42:    return 32'h05F3_0121;
      'h43:    return 32'h05F4_0121;
      default: return 32'h0000_0000;
    endcase
  endfunction

  function automatic logic read_forced(input int unsigned idx);
    return (idx == 'h40) || (idx == 'h42) || (idx == 'h43);
  endfunction

endpackage

// File: rtl/sysctl_store.sv
// Plain synchronous-read memory without reset, suitable for block RAM.
module sysctl_store #(
  parameter int unsigned WORDS  = 512,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned IDX_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              we,
  input  logic              re,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
    if (re) rdata    <= mem[idx];
  end

endmodule

// File: rtl/sysctl_shadow.sv
// Tracks which words were written since reset, and latches per-read side info.
module sysctl_shadow #(
  parameter int unsigned WORDS  = 512,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned IDX_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic              re,
  input  logic [IDX_W-1:0]  idx,
  output logic              written_q,
  output logic [DATA_W-1:0] preset_q,
  output logic              forced_q
);
  import sysctl_pkg::*;

  logic [WORDS-1:0] written;

  always_ff @(posedge clk) begin
    if (rst) begin
      written   <= '0;
      written_q <= 1'b0;
      preset_q  <= '0;
      forced_q  <= 1'b0;
    end else begin
      if (we) written[idx] <= 1'b1;
      if (re) begin
        written_q <= written[idx];
        preset_q  <= DATA_W'(preset_value(int'(idx)));
        forced_q  <= read_forced(int'(idx));
      end
    end
  end

endmodule

// File: rtl/sysctl_cmd.sv
// Command decode. The pulse flops carry no reset term, so a started pulse
// always runs its full cycle; a write is only accepted while reset is low.
module sysctl_cmd #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              cmd_we,
  input  logic [DATA_W-1:0] wdata,
  output logic              reset_req,
  output logic              shutdown_req
);
  import sysctl_pkg::*;

  req_kind_t kind;
  logic      rst_pulse = 1'b0;
  logic      sd_pulse  = 1'b0;

  always_comb kind = decode_cmd(32'(wdata));

  always_ff @(posedge clk) begin
    rst_pulse <= cmd_we && (kind == REQ_RESET);
    sd_pulse  <= cmd_we && (kind == REQ_SHUTDOWN);
  end

  assign reset_req    = rst_pulse;
  assign shutdown_req = sd_pulse;

endmodule

// File: rtl/sysctl_bank.sv
module sysctl_bank #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              reset_req,
  output logic              shutdown_req
);
  import sysctl_pkg::*;

  localparam int unsigned IDX_W = ADDR_W - 2;
  localparam int unsigned WORDS = 1 << IDX_W;

  logic [IDX_W-1:0]  idx;
  logic              acc, we, re, cmd_we;
  logic [DATA_W-1:0] ram_q, preset_q;
  logic              written_q, forced_q;

  assign idx    = bus_addr[ADDR_W-1:2];
  assign acc    = bus_valid && !rst;
  assign we     = acc && bus_write;
  assign re     = acc && !bus_write;
  assign cmd_we = we && (idx == IDX_W'(CMD_WORD));

  sysctl_store #(.WORDS(WORDS), .DATA_W(DATA_W)) u_store (
    .clk(clk), .we(we), .re(re), .idx(idx), .wdata(bus_wdata), .rdata(ram_q)
  );

  sysctl_shadow #(.WORDS(WORDS), .DATA_W(DATA_W)) u_shadow (
    .clk(clk), .rst(rst), .we(we), .re(re), .idx(idx),
    .written_q(written_q), .preset_q(preset_q), .forced_q(forced_q)
  );

  sysctl_cmd #(.DATA_W(DATA_W)) u_cmd (
    .clk(clk), .cmd_we(cmd_we), .wdata(bus_wdata),
    .reset_req(reset_req), .shutdown_req(shutdown_req)
  );

  always_comb begin
    rd_data = written_q ? ram_q : preset_q;
    if (forced_q) rd_data = rd_data | DATA_W'(FORCE_MASK);
  end

endmodule

// File: rtl/sysctl_bank_chk.sv
module sysctl_bank_chk #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              reset_req,
  input logic              shutdown_req
);
  import sysctl_pkg::*;

  logic cmd_wr, val_rst, val_sd;
  assign cmd_wr  = bus_valid && bus_write && (bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(CMD_WORD));
  assign val_rst = (bus_wdata == DATA_W'(1)) || (bus_wdata == DATA_W'(2));
  assign val_sd  = (bus_wdata == DATA_W'(3));

  assert_reset_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && val_rst) |=> reset_req);

  assert_shutdown_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && val_sd) |=> shutdown_req);

  assert_reset_cause_R7: assert property (@(posedge clk) disable iff (rst)
    reset_req |-> $past(cmd_wr && val_rst && !rst));

  assert_shutdown_cause_R7: assert property (@(posedge clk) disable iff (rst)
    shutdown_req |-> $past(cmd_wr && val_sd && !rst));

  assert_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
    !(reset_req && shutdown_req));

endmodule

bind sysctl_bank sysctl_bank_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .reset_req(reset_req), .shutdown_req(shutdown_req)
);

// File: tb/test_sysctl_bank.sv
module test_sysctl_bank;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 20;

  typedef struct packed {
    logic        wr;
    logic [11:0] addr;
    logic [31:0] data;
    logic [31:0] exp;   // expected rd_data for reads
    logic [1:0]  pulse; // {shutdown_req, reset_req} expected after the access
    logic [3:0]  req;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{1'b0, 12'h100, 32'h0, 32'h35F2_0121, 2'b00, 4'd4},  // R4 preset+force
    '{1'b0, 12'h104, 32'h0, 32'h0000_0002, 2'b00, 4'd3},  // R3
    '{1'b0, 12'h108, 32'h0, 32'h35F3_0121, 2'b00, 4'd4},  // R4
    '{1'b0, 12'h10C, 32'h0, 32'h35F4_0121, 2'b00, 4'd4},  // R4
    '{1'b0, 12'h000, 32'h0, 32'h0000_0000, 2'b00, 4'd2},  // R2 unwritten
    '{1'b1, 12'h010, 32'hA5A5_0F0F, 32'h0, 2'b00, 4'd1},  // R1
    '{1'b0, 12'h013, 32'h0, 32'hA5A5_0F0F, 2'b00, 4'd1},  // R1 low bits ignored
    '{1'b1, 12'hF00, 32'd1, 32'h0, 2'b01, 4'd5},          // R5
    '{1'b1, 12'hF00, 32'd2, 32'h0, 2'b01, 4'd5},          // R5
    '{1'b1, 12'hF00, 32'd3, 32'h0, 2'b10, 4'd6},          // R6
    '{1'b1, 12'hF00, 32'd4, 32'h0, 2'b00, 4'd7},          // R7
    '{1'b0, 12'hF00, 32'h0, 32'h0000_0004, 2'b00, 4'd7},  // R7 stored
    '{1'b1, 12'hF00, 32'd0, 32'h0, 2'b00, 4'd7},          // R7
    '{1'b1, 12'h104, 32'd1, 32'h0, 2'b00, 4'd8},          // R8
    '{1'b1, 12'hF04, 32'd3, 32'h0, 2'b00, 4'd8},          // R8
    '{1'b1, 12'h100, 32'h0, 32'h0, 2'b00, 4'd4},          // R4
    '{1'b0, 12'h100, 32'h0, 32'h3000_0000, 2'b00, 4'd4},  // R4 forced on zero
    '{1'b1, 12'h108, 32'h0000_00FF, 32'h0, 2'b00, 4'd4},
    '{1'b0, 12'h104, 32'h0, 32'h0000_0001, 2'b00, 4'd4},  // R4 not forced
    '{1'b0, 12'h108, 32'h0, 32'h3000_00FF, 2'b00, 4'd4}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rd_data;
  logic        reset_req, shutdown_req;
  int          checks = 0;
  int          fails = 0;
  bit          done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sysctl_bank i_sysctl_bank (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_data(rd_data),
    .reset_req(reset_req), .shutdown_req(shutdown_req)
  );

  task automatic check(input bit ok, input int req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // One access, then sample in the following cycle away from the edge.
  task automatic access(input logic wr, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R2: reset state
    check(rd_data == 32'h0, 2, "rd_data in reset", rd_data, 32'h0);
    check({shutdown_req, reset_req} == 2'b00, 2, "requests in reset",
          {30'h0, shutdown_req, reset_req}, 32'h0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      access(VECS[i].wr, VECS[i].addr, VECS[i].data);
      if (!VECS[i].wr)
        check(rd_data == VECS[i].exp, int'(VECS[i].req), "read data", rd_data, VECS[i].exp);
      // R9 is covered here too: expected pulses are never both high
      check({shutdown_req, reset_req} == VECS[i].pulse, int'(VECS[i].req), "request lines",
            {30'h0, shutdown_req, reset_req}, {30'h0, VECS[i].pulse});
    end

    // R5: pulse lasts exactly one cycle
    access(1'b1, 12'hF00, 32'd1);
    @(negedge clk);
    check(reset_req == 1'b0, 5, "reset_req after pulse", {31'h0, reset_req}, 32'h0);

    // R10: rst rising in the pulse cycle does not cut the pulse
    access(1'b1, 12'hF00, 32'd2);
    rst = 1'b1;
    #1;
    check(reset_req == 1'b1, 10, "pulse under rst", {31'h0, reset_req}, 32'h1);
    @(negedge clk);
    check(reset_req == 1'b0, 10, "pulse end under rst", {31'h0, reset_req}, 32'h0);

    // R10: strobes ignored while rst is high
    access(1'b1, 12'hF00, 32'd3);
    check(shutdown_req == 1'b0, 10, "shutdown during rst", {31'h0, shutdown_req}, 32'h0);
    access(1'b1, 12'h020, 32'h1234_5678);
    rst = 1'b0;

    access(1'b0, 12'h020, 32'h0);
    check(rd_data == 32'h0, 10, "write during rst stored", rd_data, 32'h0);
    // R11: contents restored to reset values
    access(1'b0, 12'h010, 32'h0);
    check(rd_data == 32'h0, 11, "written word cleared", rd_data, 32'h0);
    access(1'b0, 12'h108, 32'h0);
    check(rd_data == 32'h35F3_0121, 11, "preset restored", rd_data, 32'h35F3_0121);
    access(1'b0, 12'h104, 32'h0);
    check(rd_data == 32'h0000_0002, 11, "preset restored", rd_data, 32'h2);
    access(1'b0, 12'hF00, 32'h0);
    check(rd_data == 32'h0, 11, "command word cleared", rd_data, 32'h0);
    // R1: rd_data holds between reads
    repeat (3) @(negedge clk);
    check(rd_data == 32'h0, 1, "rd_data hold", rd_data, 32'h0);
    access(1'b1, 12'hFFC, 32'hDEAD_BEEF);
    access(1'b0, 12'hFFE, 32'h0);
    check(rd_data == 32'hDEAD_BEEF, 1, "top word", rd_data, 32'hDEAD_BEEF);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule